// File: doc/BRIEF.md
# Mode-Selectable Odd Parity Unit

This block sits on the parallel side of a multi-channel serial transceiver and handles odd parity for every lane. Going toward the line, it checks each incoming transmit word (an 8-bit byte, and in some modes also a 2-bit control field) against a parity bit that arrives with it. It raises a one-cycle error flag for each word that fails. Coming from the line, it registers each received byte and its 3-bit status field. It then generates an odd parity bit over the byte and over none, two or all three of the status bits.

One static 2-bit coverage mode and one codec-enable input are shared by all lanes. Together they decide which bits each check and each generated bit covers. The lowest mode switches checking off and releases the receive parity outputs. A per-lane output-enable models that released state, and the parity output is driven to 0 while it is released.

Top module: `odd_parity_quad`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tx_perr` is 0, and `rx_data` and `rx_stat` are 0.
- R2: With `par_mode` = 00 (off), `tx_perr` stays 0 for any input, and every `rx_par_oe` and `rx_par` is 0.
- R3: With `par_mode` = 01 and `codec_on` = 1, a transmit word is in error when the count of ones in `tx_data` plus `tx_par` is even. `tx_ctl` has no effect.
- R4: With `par_mode` = 01 and `codec_on` = 0, a transmit word is in error when the count of ones in `tx_data`, `tx_ctl[1:0]` and `tx_par` together is even.
- R5: With `par_mode` = 10, the transmit check covers `tx_data`, `tx_ctl[1:0]` and `tx_par`, whatever the value of `codec_on`.
- R6: With `par_mode` = 01 and `codec_on` = 1, `rx_par` makes the count of ones in `rx_data` plus `rx_par` odd. `rx_stat` has no effect on it.
- R7: With `par_mode` = 01 and `codec_on` = 0, `rx_par` makes the count of ones in `rx_data`, `rx_stat[1:0]` and `rx_par` odd. `rx_stat[2]` has no effect on it.
- R8: With `par_mode` = 10, `rx_par` makes the count of ones in `rx_data`, `rx_stat[2:0]` and `rx_par` odd, whatever the value of `codec_on`.
- R9: `par_mode` = 11 behaves exactly as 10.
- R10: `tx_perr` for a lane rises in the cycle after a failing word that is sampled with `tx_valid` high. It is high for that one cycle only. A word sampled with `tx_valid` low never raises it.
- R11: `rx_data` and `rx_stat` are `rx_data_in` and `rx_stat_in` delayed by one clock. `rx_par` belongs to the registered values and appears in the same cycle. `rx_par_oe` is 1 in every mode other than 00.
- R12: Each lane's error flag and parity bit depend only on that lane's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both directions |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 2 | Coverage mode: 00 off, 01 mid, 10 full, 11 full |
| codec_on | input | 1 | 1 when the line codec is in use |
| tx_valid | input | 4 | Per-lane transmit word strobe |
| tx_data | input | 32 | Transmit bytes, lane n at [8n+7:8n] |
| tx_ctl | input | 8 | Transmit control fields, lane n at [2n+1:2n] |
| tx_par | input | 4 | Supplied transmit parity bits |
| tx_perr | output | 4 | Registered per-lane parity error flags |
| rx_data_in | input | 32 | Receive bytes from the decoder |
| rx_stat_in | input | 12 | Receive status, lane n at [3n+2:3n] |
| rx_data | output | 32 | Registered receive bytes |
| rx_stat | output | 12 | Registered receive status |
| rx_par | output | 4 | Generated odd parity bits |
| rx_par_oe | output | 4 | Per-lane parity output enable |

## Verification
The hardest case to reach is one where an uncovered field changes while the covered bits stay the same. In that case a wrong coverage choice flips the output, but only for some patterns. The bench drives words whose covered part is held fixed and toggles only the control field or the status bits above the covered width. It also drives random words in every mode and codec setting and compares all lanes against a parity model built from the requirements. Varying both the codec and the mode across the same data separates the mid-mode dependence on the codec from the full mode's indifference to it.

// File: rtl/odd_parity_pkg.sv
package odd_parity_pkg;

  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_MID  = 2'b01,
    PM_FULL = 2'b10,
    PM_ALT  = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic       check_en;
    logic       ctl_cov;
    logic       gen_oe;
    logic [2:0] stat_mask;
  } cov_sel_t;

endpackage

// File: rtl/parity_cov_decode.sv
module parity_cov_decode
  import odd_parity_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic [1:0]    par_mode,
  input  logic          codec_on,
  output logic          check_en,
  output logic          ctl_cov,
  output logic          gen_oe,
  output logic [SW-1:0] stat_mask
);

  localparam int LOW_W = 2;
  localparam logic [SW-1:0] MASK_NONE = '0;
  localparam logic [SW-1:0] MASK_LOW  = SW'((1 << LOW_W) - 1);
  localparam logic [SW-1:0] MASK_ALL  = '1;

  par_mode_e mode;
  assign mode = par_mode_e'(par_mode);

  always_comb begin
    check_en  = 1'b1;
    gen_oe    = 1'b1;
    ctl_cov   = 1'b1;
    stat_mask = MASK_ALL;
    unique case (mode)
      PM_OFF: begin
        check_en  = 1'b0;
        gen_oe    = 1'b0;
        ctl_cov   = 1'b0;
        stat_mask = MASK_NONE;
      end
      PM_MID: begin
        ctl_cov   = !codec_on;
        stat_mask = codec_on ? MASK_NONE : MASK_LOW;
      end
      default: begin
        ctl_cov   = 1'b1;
        stat_mask = MASK_ALL;
      end
    endcase
  end

  always_comb begin
    if (mode != PM_OFF) begin
      a_on_modes_r9: assert (check_en && gen_oe);
    end
  end

endmodule

// File: rtl/parity_tx_check.sv
module parity_tx_check #(
  parameter int DW = 8,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          check_en,
  input  logic          ctl_cov,
  input  logic          valid,
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] ctl,
  input  logic          par,
  output logic          err
);

  logic [CW-1:0] ctl_used;
  logic          ones_odd;
  logic          err_q;

  assign ctl_used = ctl & {CW{ctl_cov}};
  assign ones_odd = ^{data, ctl_used, par};

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= valid && check_en && !ones_odd;
  end

  assign err = err_q;

  p_err_gated_r10: assert property (@(posedge clk) disable iff (rst)
    (!valid || !check_en) |=> !err);

  p_ctl_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (valid && check_en && !ctl_cov && (^{data, par})) |=> !err);

  p_ctl_counted_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && check_en && ctl_cov && !(^{data, ctl, par})) |=> err);

endmodule

// File: rtl/parity_rx_gen.sv
module parity_rx_gen #(
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gen_oe,
  input  logic [SW-1:0] stat_mask,
  input  logic [DW-1:0] data_in,
  input  logic [SW-1:0] stat_in,
  output logic [DW-1:0] data_q,
  output logic [SW-1:0] stat_q,
  output logic          par,
  output logic          oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      stat_q <= '0;
    end else begin
      data_q <= data_in;
      stat_q <= stat_in;
    end
  end

  logic [SW-1:0] stat_used;
  assign stat_used = stat_q & stat_mask;
  assign par       = gen_oe && !(^{data_q, stat_used});
  assign oe        = gen_oe;

  p_top_stat_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (!stat_mask[SW-1] && $stable(data_q) && $stable(stat_q[SW-2:0])
     && $stable(stat_mask) && $stable(gen_oe)) |-> $stable(par));

  p_full_odd_r8: assert property (@(posedge clk) disable iff (rst)
    (gen_oe && (&stat_mask)) |-> (^{data_q, stat_q, par}));

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !par);

endmodule

// File: rtl/odd_parity_quad.sv
module odd_parity_quad #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int CW  = 2,
  parameter int SW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        par_mode,
  input  logic              codec_on,
  input  logic [NCH-1:0]    tx_valid,
  input  logic [NCH*DW-1:0] tx_data,
  input  logic [NCH*CW-1:0] tx_ctl,
  input  logic [NCH-1:0]    tx_par,
  output logic [NCH-1:0]    tx_perr,
  input  logic [NCH*DW-1:0] rx_data_in,
  input  logic [NCH*SW-1:0] rx_stat_in,
  output logic [NCH*DW-1:0] rx_data,
  output logic [NCH*SW-1:0] rx_stat,
  output logic [NCH-1:0]    rx_par,
  output logic [NCH-1:0]    rx_par_oe
);

  logic          check_en;
  logic          ctl_cov;
  logic          gen_oe;
  logic [SW-1:0] stat_mask;

  parity_cov_decode #(.SW(SW)) u_decode (
    .par_mode  (par_mode),
    .codec_on  (codec_on),
    .check_en  (check_en),
    .ctl_cov   (ctl_cov),
    .gen_oe    (gen_oe),
    .stat_mask (stat_mask)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    parity_tx_check #(.DW(DW), .CW(CW)) u_tx (
      .clk      (clk),
      .rst      (rst),
      .check_en (check_en),
      .ctl_cov  (ctl_cov),
      .valid    (tx_valid[c]),
      .data     (tx_data[c*DW +: DW]),
      .ctl      (tx_ctl[c*CW +: CW]),
      .par      (tx_par[c]),
      .err      (tx_perr[c])
    );

    parity_rx_gen #(.DW(DW), .SW(SW)) u_rx (
      .clk       (clk),
      .rst       (rst),
      .gen_oe    (gen_oe),
      .stat_mask (stat_mask),
      .data_in   (rx_data_in[c*DW +: DW]),
      .stat_in   (rx_stat_in[c*SW +: SW]),
      .data_q    (rx_data[c*DW +: DW]),
      .stat_q    (rx_stat[c*SW +: SW]),
      .par       (rx_par[c]),
      .oe        (rx_par_oe[c])
    );
  end

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    ((tx_perr != '0) && (tx_valid == '0)) |=> (tx_perr == '0));

  p_off_no_err_r2: assert property (@(posedge clk) disable iff (rst)
    (par_mode == 2'b00) |=> (tx_perr == '0));

endmodule

// File: tb/odd_parity_quad_bench.sv
module odd_parity_quad_bench;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int CW  = 2;
  localparam int SW  = 3;

  logic              clk = 1'b0;
  logic              rst;
  logic [1:0]        par_mode;
  logic              codec_on;
  logic [NCH-1:0]    tx_valid;
  logic [NCH*DW-1:0] tx_data;
  logic [NCH*CW-1:0] tx_ctl;
  logic [NCH-1:0]    tx_par;
  logic [NCH-1:0]    tx_perr;
  logic [NCH*DW-1:0] rx_data_in;
  logic [NCH*SW-1:0] rx_stat_in;
  logic [NCH*DW-1:0] rx_data;
  logic [NCH*SW-1:0] rx_stat;
  logic [NCH-1:0]    rx_par;
  logic [NCH-1:0]    rx_par_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  odd_parity_quad u_odd_parity_quad (
    .clk(clk), .rst(rst), .par_mode(par_mode), .codec_on(codec_on),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ctl(tx_ctl), .tx_par(tx_par),
    .tx_perr(tx_perr), .rx_data_in(rx_data_in), .rx_stat_in(rx_stat_in),
    .rx_data(rx_data), .rx_stat(rx_stat), .rx_par(rx_par), .rx_par_oe(rx_par_oe)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model taken from the requirements: which bits are covered per mode.
  function automatic logic m_on(logic [1:0] m);
    return m != 2'b00;
  endfunction
  function automatic logic m_ctl(logic [1:0] m, logic cd);
    return (m == 2'b01) ? !cd : (m != 2'b00);
  endfunction
  function automatic logic [2:0] m_stat(logic [1:0] m, logic cd);
    if (m == 2'b00) return 3'b000;
    if (m == 2'b01) return cd ? 3'b000 : 3'b011;
    return 3'b111;
  endfunction

  // Drive one word on every lane, advance one clock and compare all outputs.
  task automatic step(string req);
    logic [NCH-1:0] e_err, e_par;
    logic [NCH*DW-1:0] d_in = rx_data_in;
    logic [NCH*SW-1:0] s_in = rx_stat_in;
    for (int c = 0; c < NCH; c++) begin
      logic [1:0] cf = m_ctl(par_mode, codec_on) ? tx_ctl[c*CW +: CW] : 2'b00;
      logic [2:0] sf = rx_stat_in[c*SW +: SW] & m_stat(par_mode, codec_on);
      e_err[c] = m_on(par_mode) && tx_valid[c]
                 && !(^{tx_data[c*DW +: DW], cf, tx_par[c]});
      e_par[c] = m_on(par_mode) && !(^{rx_data_in[c*DW +: DW], sf});
    end
    @(negedge clk);
    check({req, " tx_perr"}, 64'(tx_perr), 64'(e_err));
    check({req, " rx_par"}, 64'(rx_par), 64'(e_par));
    check({req, " R11 rx_data"}, 64'(rx_data), 64'(d_in));
    check({req, " R11 rx_stat"}, 64'(rx_stat), 64'(s_in));
    check({req, " R11 rx_par_oe"}, 64'(rx_par_oe), m_on(par_mode) ? 64'hF : 64'h0);
  endtask

  task automatic rand_words(string req, int n);
    for (int i = 0; i < n; i++) begin
      tx_valid   = 4'($urandom);
      tx_data    = $urandom;
      tx_ctl     = 8'($urandom);
      tx_par     = 4'($urandom);
      rx_data_in = $urandom;
      rx_stat_in = 12'($urandom);
      step(req);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; par_mode = 2'b10; codec_on = 1'b1;
    tx_valid = '1; tx_data = '0; tx_ctl = '0; tx_par = '0;
    rx_data_in = '1; rx_stat_in = '1;
    repeat (3) @(negedge clk);
    check("R1 tx_perr in reset", 64'(tx_perr), 64'h0);
    check("R1 rx_data in reset", 64'(rx_data), 64'h0);
    check("R1 rx_stat in reset", 64'(rx_stat), 64'h0);
    rst = 1'b0;
    tx_valid = '0;
  endtask

  task automatic t_off();
    par_mode = 2'b00; codec_on = 1'b0;
    tx_valid = '1; tx_data = '0; tx_par = '0; tx_ctl = '0;
    rx_data_in = '0; rx_stat_in = '0;
    step("R2 off all-zero");
    rand_words("R2 off random", 20);
  endtask

  task automatic t_mid_codec();
    par_mode = 2'b01; codec_on = 1'b1;
    // data 0x03 has two ones; par 1 makes it odd; ctl must not matter
    tx_valid = '1; tx_data = {4{8'h03}}; tx_par = '1; tx_ctl = {4{2'b01}};
    rx_data_in = {4{8'h01}}; rx_stat_in = {4{3'b111}};
    step("R3 R6 ctl and stat ignored");
    check("R3 no error with odd ctl", 64'(tx_perr), 64'h0);
    check("R6 rx_par over data only", 64'(rx_par), 64'h0);
    rand_words("R3 R6 mid codec random", 30);
  endtask

  task automatic t_mid_nocodec();
    par_mode = 2'b01; codec_on = 1'b0;
    tx_valid = '1; tx_data = {4{8'h03}}; tx_par = '1; tx_ctl = {4{2'b01}};
    rx_data_in = {4{8'h01}}; rx_stat_in = {4{3'b100}};
    step("R4 R7 mid no codec");
    check("R4 ctl counted gives error", 64'(tx_perr), 64'hF);
    check("R7 stat bit2 ignored", 64'(rx_par), 64'h0);
    rx_stat_in = {4{3'b101}};
    step("R7 stat bit0 counted");
    check("R7 rx_par with stat0", 64'(rx_par), 64'hF);
    rand_words("R4 R7 mid no codec random", 30);
  endtask

  task automatic t_full();
    for (int cd = 0; cd < 2; cd++) begin
      par_mode = 2'b10; codec_on = cd[0];
      tx_valid = '1; tx_data = {4{8'h03}}; tx_par = '1; tx_ctl = {4{2'b01}};
      rx_data_in = {4{8'h01}}; rx_stat_in = {4{3'b100}};
      step("R5 R8 full");
      check("R5 ctl counted", 64'(tx_perr), 64'hF);
      check("R8 stat bit2 counted", 64'(rx_par), 64'hF);
      rand_words("R5 R8 full random", 20);
    end
  endtask

  task automatic t_alt();
    for (int cd = 0; cd < 2; cd++) begin
      par_mode = 2'b11; codec_on = cd[0];
      tx_valid = '1; tx_data = {4{8'h03}}; tx_par = '1; tx_ctl = {4{2'b10}};
      rx_data_in = {4{8'h00}}; rx_stat_in = {4{3'b100}};
      step("R9 mode 11");
      check("R9 ctl counted", 64'(tx_perr), 64'hF);
      check("R9 stat bit2 counted", 64'(rx_par), 64'h0);
      rand_words("R9 mode 11 random", 20);
    end
  endtask

  task automatic t_pulse();
    par_mode = 2'b10; codec_on = 1'b1;
    tx_valid = '1; tx_data = '0; tx_ctl = '0; tx_par = '0;
    step("R10 failing word");
    check("R10 error raised", 64'(tx_perr), 64'hF);
    tx_valid = '0;
    step("R10 no word");
    check("R10 single cycle", 64'(tx_perr), 64'h0);
    tx_valid = 4'b0000; tx_data = '0;
    step("R10 failing word without valid");
    check("R10 invalid ignored", 64'(tx_perr), 64'h0);
  endtask

  task automatic t_lanes();
    par_mode = 2'b10; codec_on = 1'b0;
    tx_valid = '1; tx_ctl = '0;
    tx_data = {8'h00, 8'h01, 8'h00, 8'h01}; tx_par = 4'b0000;
    rx_data_in = {8'h00, 8'h01, 8'h03, 8'h07}; rx_stat_in = '0;
    step("R12 lane independence");
    check("R12 per-lane errors", 64'(tx_perr), 64'b1010);
    check("R12 per-lane parity", 64'(rx_par), 64'b1010);
  endtask

  initial begin
    t_reset();
    t_off();
    t_mid_codec();
    t_mid_nocodec();
    t_full();
    t_alt();
    t_pulse();
    t_lanes();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule